// File: doc/BRIEF.md
# Comma Word Aligner

This block sits behind one lane's deserializer and turns a raw bit stream into framed 10-bit code groups. Each input beat carries `WORDS` code groups' worth of bits, with bit 0 the earliest bit on the wire. The block keeps the last symbol's worth of bits from the previous beat. Every beat it searches every candidate start position in the joined window for the K28.5 comma in either running-disparity form. When it finds one, it moves its word boundary to that comma. It then emits `WORDS` aligned code groups per beat, each with a flag that says whether that group is a comma.

Realignment is allowed only while `align_en` is high. The lock controller holds `align_en` high while the lane searches for sync and drops it once the lane is locked. After that, a comma that bit errors create at a different bit position cannot move the boundary. Commas that land on the held boundary are still flagged.

Both stream interfaces use valid/ready. A beat moves on any edge where valid and ready are both high. `in_ready` is high whenever the output register is empty or being drained. While `out_valid` is high and `out_ready` is low, the output beat and its flags stay frozen and no new input is taken. `in_valid` may drop between beats without breaking the bit stream.

Top module: `comma_aligner`

## Requirements
- R1: While `rst_n` is low and after its release, `out_valid` is 0 and `in_ready` is 1. The held tail bits reset to zero and the word boundary resets to offset 0.
- R2: `in_data` bit 0 is the earliest bit. Output word m of a beat occupies `out_data[10m+9:10m]`, with its bit 0 earliest. For accepted beat n and boundary offset d, word m holds stream bits starting at 20n-10+d+10m (for WORDS=2). Bits before the first beat read as zero.
- R3: Both comma forms are recognised. Written earliest bit first they are 0011111010 and 1100000101, which are 10'h17C and 10'h283 as vectors with bit 0 earliest. `out_comma[m]` is 1 exactly when output word m equals one of them.
- R4: With `align_en` high, a comma that starts at any of the 10 bit offsets moves the boundary to that offset. The comma is output as a flagged word in the same beat, and later words follow the new boundary.
- R5: With `align_en` low, the boundary offset does not change. A comma at another offset is output unaligned and is not flagged.
- R6: With `align_en` low, a comma that starts on the held boundary is still output with its flag set.
- R7: With `out_ready` high, a beat accepted on edge k appears on `out_valid`/`out_data` after edge k+1 and not before.
- R8: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0, and `out_data`, `out_comma` and `out_valid` hold their values. No beat is lost or repeated.
- R9: When two commas at different offsets start inside the same search window, the earlier one in the stream sets the boundary.
- R10: Idle cycles (`in_valid` low) between beats leave the joined stream unchanged. Output words match the gap-free case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| align_en | input | 1 | High allows the boundary to move to a new comma |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block can take an input beat |
| in_data | input | WORDS*10 | Raw deserialized bits, bit 0 earliest |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Sink can take the output beat |
| out_data | output | WORDS*10 | Aligned code groups, word 0 in the low bits |
| out_comma | output | WORDS | Per-word flag, set when that word is a comma |

## Verification
The hardest case to reach from the ports is a window that holds two commas at different offsets, or a comma that lands off the held boundary just after lock. Random data almost never produces either. The bench builds each bit stream explicitly: it places junk bits of a chosen length, then run-limited filler and data words that cannot form a comma, then commas at exact stream positions. It switches `align_en` only during idle gaps between beats. It predicts every output word from the stream positions and the offset the requirements imply, and it drives back-pressure with an irregular `out_ready` pattern while the stream flows.

// File: rtl/comma_align_pkg.sv
package comma_align_pkg;

  localparam int SYM_W = 10;
  localparam int OFF_W = $clog2(SYM_W);

  // comma codes, vector bit 0 = earliest bit on the wire
  localparam logic [SYM_W-1:0] COMMA_RDN = 10'b0101111100;
  localparam logic [SYM_W-1:0] COMMA_RDP = 10'b1010000011;

  function automatic logic is_comma(input logic [SYM_W-1:0] sym);
    return (sym == COMMA_RDN) || (sym == COMMA_RDP);
  endfunction

endpackage

// File: rtl/ca_comma_scan.sv
module ca_comma_scan
  import comma_align_pkg::*;
#(
  parameter int WORDS = 2
) (
  input  logic [(WORDS+1)*SYM_W-1:0] win,
  output logic [WORDS*SYM_W-1:0]     pos_hit
);

  localparam int NPOS = WORDS * SYM_W;

  // one comparator pair per candidate start position
  for (genvar j = 0; j < NPOS; j++) begin : g_pos
    assign pos_hit[j] = is_comma(win[j +: SYM_W]);
  end

endmodule

// File: rtl/ca_offset_ctrl.sv
module ca_offset_ctrl
  import comma_align_pkg::*;
#(
  parameter int WORDS = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   step,
  input  logic                   align_en,
  input  logic [WORDS*SYM_W-1:0] pos_hit,
  output logic [OFF_W-1:0]       off_sel
);

  logic [SYM_W-1:0] hit_off;
  logic [OFF_W-1:0] low_off;
  logic [OFF_W-1:0] off_q;

  // fold the hit positions onto the ten bit offsets
  always_comb begin
    hit_off = '0;
    for (int o = 0; o < SYM_W; o++) begin
      for (int m = 0; m < WORDS; m++) begin
        hit_off[o] = hit_off[o] | pos_hit[o + m*SYM_W];
      end
    end
  end

  // lowest offset first: inside one window that is also the earliest comma
  always_comb begin
    low_off = '0;
    for (int o = SYM_W-1; o >= 0; o--) begin
      if (hit_off[o]) low_off = OFF_W'(o);
    end
  end

  assign off_sel = (align_en && (|hit_off)) ? low_off : off_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    off_q <= '0;
    else if (step) off_q <= off_sel;
  end

endmodule

// File: rtl/ca_barrel.sv
module ca_barrel
  import comma_align_pkg::*;
#(
  parameter int WORDS = 2
) (
  input  logic [(WORDS+1)*SYM_W-1:0] win,
  input  logic [WORDS*SYM_W-1:0]     pos_hit,
  input  logic [OFF_W-1:0]           off,
  output logic [WORDS*SYM_W-1:0]     words,
  output logic [WORDS-1:0]           flags
);

  always_comb begin
    words = '0;
    flags = '0;
    for (int o = 0; o < SYM_W; o++) begin
      if (int'(off) == o) begin
        for (int m = 0; m < WORDS; m++) begin
          words[m*SYM_W +: SYM_W] = win[o + m*SYM_W +: SYM_W];
          flags[m]                = pos_hit[o + m*SYM_W];
        end
      end
    end
  end

endmodule

// File: rtl/comma_aligner.sv
module comma_aligner
  import comma_align_pkg::*;
#(
  parameter int WORDS = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   align_en,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [WORDS*SYM_W-1:0] in_data,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [WORDS*SYM_W-1:0] out_data,
  output logic [WORDS-1:0]       out_comma
);

  localparam int IN_W  = WORDS * SYM_W;
  localparam int WIN_W = IN_W + SYM_W;

  logic             advance;
  logic             take;
  logic [SYM_W-1:0] tail_q;
  logic [WIN_W-1:0] win_c;
  logic [IN_W-1:0]  hit_c;

  logic             v1_q;
  logic [WIN_W-1:0] win_q;
  logic [IN_W-1:0]  hit_q;

  logic [OFF_W-1:0] off_sel;
  logic [IN_W-1:0]  sh_words;
  logic [WORDS-1:0] sh_flags;

  // whole pipe moves together; it stalls only when the output is held
  assign advance  = !out_valid || out_ready;
  assign in_ready = advance;
  assign take     = in_valid && advance;

  assign win_c = {in_data, tail_q};

  ca_comma_scan #(.WORDS(WORDS)) u_scan (
    .win     (win_c),
    .pos_hit (hit_c)
  );

  // stage 1: joined window and its hit map
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tail_q <= '0;
      v1_q   <= 1'b0;
      win_q  <= '0;
      hit_q  <= '0;
    end else begin
      if (advance) v1_q <= in_valid;
      if (take) begin
        tail_q <= in_data[IN_W-1 -: SYM_W];
        win_q  <= win_c;
        hit_q  <= hit_c;
      end
    end
  end

  ca_offset_ctrl #(.WORDS(WORDS)) u_off (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (advance && v1_q),
    .align_en (align_en),
    .pos_hit  (hit_q),
    .off_sel  (off_sel)
  );

  ca_barrel #(.WORDS(WORDS)) u_shift (
    .win     (win_q),
    .pos_hit (hit_q),
    .off     (off_sel),
    .words   (sh_words),
    .flags   (sh_flags)
  );

  // stage 2: aligned output register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_comma <= '0;
    end else if (advance) begin
      out_valid <= v1_q;
      if (v1_q) begin
        out_data  <= sh_words;
        out_comma <= sh_flags;
      end else begin
        out_comma <= '0;
      end
    end
  end

endmodule

// File: rtl/comma_aligner_chk.sv
module comma_aligner_chk
  import comma_align_pkg::*;
#(
  parameter int WORDS = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   align_en,
  input logic                   in_ready,
  input logic                   out_valid,
  input logic                   out_ready,
  input logic [WORDS*SYM_W-1:0] out_data,
  input logic [WORDS-1:0]       out_comma,
  input logic [OFF_W-1:0]       off_q
);

  p_reset_idle_r1: assert property (@(posedge clk)
    !rst_n |-> !out_valid && in_ready);

  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_comma));

  p_stall_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  p_hold_offset_r5: assert property (@(posedge clk) disable iff (!rst_n)
    off_q != $past(off_q) |-> $past(align_en));

  p_move_flags_r4: assert property (@(posedge clk) disable iff (!rst_n)
    off_q != $past(off_q) |-> out_valid && (out_comma != '0));

  for (genvar m = 0; m < WORDS; m++) begin : g_word
    p_flag_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
      out_comma[m] |-> out_valid && is_comma(out_data[m*SYM_W +: SYM_W]));
  end

endmodule

bind comma_aligner comma_aligner_chk #(.WORDS(WORDS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .align_en  (align_en),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_comma (out_comma),
  .off_q     (u_off.off_q)
);

// File: tb/test_comma_aligner.sv
module test_comma_aligner;

  localparam int CLK_P = 10;
  localparam int WORDS = 2;
  localparam int SW    = 10;
  localparam int IN_W  = WORDS * SW;
  localparam logic [9:0] K_N   = 10'b0101111100;
  localparam logic [9:0] K_P   = 10'b1010000011;
  localparam logic [9:0] FILL  = 10'b0101010101;
  localparam logic [9:0] D0    = 10'b1011001101;
  localparam logic [9:0] D1    = 10'b0100110110;
  localparam logic [9:0] D2    = 10'b1101001011;
  localparam logic [9:0] D3    = 10'b0010110100;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            align_en;
  logic            in_valid;
  logic            in_ready;
  logic [IN_W-1:0] in_data;
  logic            out_valid;
  logic            out_ready;
  logic [IN_W-1:0] out_data;
  logic [WORDS-1:0] out_comma;

  int vectors = 0;
  int fails   = 0;

  logic strm [0:511];
  int   slen;
  int   eoff [0:63];
  logic [IN_W-1:0]  rec_data [0:63];
  logic [WORDS-1:0] rec_flag [0:63];
  int   rec_n;

  logic            bp_on = 1'b0;
  logic            stall_prev = 1'b0;
  logic [IN_W-1:0] held_d;
  logic [WORDS-1:0] held_f;

  always #(CLK_P/2) clk = ~clk;

  comma_aligner #(.WORDS(WORDS)) i_comma_aligner (
    .clk(clk), .rst_n(rst_n), .align_en(align_en),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_comma(out_comma)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // output monitor, sampled at the falling edge
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready && rec_n < 64) begin
      rec_data[rec_n] = out_data;
      rec_flag[rec_n] = out_comma;
      rec_n++;
    end
    if (bp_on) begin
      if (stall_prev)
        chk(out_valid && out_data == held_d && out_comma == held_f, "R8",
            "stalled beat changed", {out_valid, out_comma, out_data},
            {1'b1, held_f, held_d});
      if (out_valid && !out_ready)
        chk(!in_ready, "R8", "in_ready while stalled", 64'(in_ready), 64'd0);
      stall_prev = out_valid && !out_ready;
      held_d = out_data;
      held_f = out_comma;
    end
  end

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; out_ready = 1'b1;
    align_en = 1'b1; stall_prev = 1'b0;
    tick(3);
    rst_n = 1'b1;
    rec_n = 0; slen = 0;
    for (int k = 0; k < 64; k++) eoff[k] = 0;
    tick(1);
  endtask

  task automatic put_word(input logic [9:0] w);
    for (int b = 0; b < SW; b++) begin strm[slen] = w[b]; slen++; end
  endtask

  task automatic put_junk(input int n);
    for (int b = 0; b < n; b++) begin strm[slen] = logic'(slen % 2); slen++; end
  endtask

  task automatic pad();
    while (slen % IN_W != 0) put_junk(1);
  endtask

  task automatic set_off(input int from, input int val);
    for (int k = from; k < 64; k++) eoff[k] = val;
  endtask

  function automatic logic sbit(input int idx);
    if (idx < 0 || idx >= slen) return 1'b0;
    return strm[idx];
  endfunction

  task automatic drive_beats(input int first, input int last, input int gap);
    logic acc;
    for (int n = first; n <= last; n++) begin
      for (int b = 0; b < IN_W; b++) in_data[b] = strm[n*IN_W + b];
      in_valid = 1'b1;
      do begin
        @(negedge clk); acc = in_ready;
        @(posedge clk); #1;
      end while (!acc);
      in_valid = 1'b0;
      tick(gap);
    end
  endtask

  // predicted output from stream positions (R2) and the expected offset
  task automatic compare_run(input int nb, input string req);
    chk(rec_n == nb, req, "beat count", 64'(rec_n), 64'(nb));
    for (int k = 0; k < nb; k++) begin
      logic [IN_W-1:0]  ed;
      logic [WORDS-1:0] ef;
      for (int m = 0; m < WORDS; m++) begin
        for (int b = 0; b < SW; b++)
          ed[m*SW + b] = sbit(k*IN_W - SW + eoff[k] + m*SW + b);
        ef[m] = (ed[m*SW +: SW] == K_N) || (ed[m*SW +: SW] == K_P);
      end
      chk(rec_data[k] == ed && rec_flag[k] == ef, req, $sformatf("beat %0d", k),
          {rec_flag[k], rec_data[k]}, {ef, ed});
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; out_ready = 1'b1; align_en = 1'b1;
    tick(2);
    @(negedge clk);
    chk(!out_valid && in_ready, "R1", "during reset", {out_valid, in_ready}, 64'b01);
    rst_n = 1'b1;
    tick(2);
    @(negedge clk);
    chk(!out_valid && in_ready, "R1", "after reset", {out_valid, in_ready}, 64'b01);
  endtask

  task automatic t_latency();
    do_reset();
    in_data = {FILL, FILL}; in_valid = 1'b1;
    @(posedge clk); #1; in_valid = 1'b0;
    @(negedge clk);
    chk(!out_valid, "R7", "valid one edge after accept", 64'(out_valid), 64'd0);
    @(negedge clk);
    chk(out_valid && out_data == {FILL, 10'b0}, "R7", "beat two edges after accept",
        {out_valid, out_data}, {1'b1, FILL, 10'b0});
    @(negedge clk);
    chk(!out_valid, "R7", "single beat only", 64'(out_valid), 64'd0);
  endtask

  // comma at bit offset s, either form, realignment enabled
  task automatic t_align(input int s);
    do_reset();
    put_junk(s); put_word(FILL); put_word(FILL); put_word(FILL);
    put_word((s % 2) ? K_P : K_N);
    put_word(D0); put_word(D1); put_word(D2); put_word(D3); put_word(FILL); put_word(FILL);
    pad();
    set_off(2, s);
    drive_beats(0, slen/IN_W - 1, 0);
    tick(4);
    compare_run(slen/IN_W, $sformatf("R4 R3 R2 offset %0d", s));
  endtask

  task automatic t_hold();
    do_reset();
    align_en = 1'b0;
    put_junk(4); put_word(FILL); put_word(FILL); put_word(FILL);
    put_word(K_N); put_word(D1); put_word(D2); put_word(FILL);
    pad();
    drive_beats(0, slen/IN_W - 1, 0);
    tick(4);
    compare_run(slen/IN_W, "R5");
    align_en = 1'b1;
  endtask

  task automatic t_hold_flag();
    do_reset();
    put_junk(3); put_word(FILL); put_word(FILL); put_word(FILL);
    put_word(K_N);
    put_word(D0); put_word(D1); put_word(D2); put_word(D3); put_word(FILL);
    put_word(K_P);
    put_word(FILL); put_word(FILL);
    put_junk(6); put_word(K_N);
    put_word(FILL); put_word(FILL); put_word(FILL);
    pad();
    set_off(2, 3);
    drive_beats(0, 2, 0);
    tick(4);
    align_en = 1'b0;
    drive_beats(3, slen/IN_W - 1, 0);
    tick(4);
    compare_run(slen/IN_W, "R6 R5 R10");
    align_en = 1'b1;
  endtask

  task automatic t_earliest();
    do_reset();
    put_junk(6); put_word(FILL); put_word(FILL); put_word(FILL);
    put_word(K_P); put_junk(3); put_word(K_N);
    put_word(FILL); put_word(D3); put_word(D0); put_word(FILL);
    pad();
    set_off(2, 6);
    drive_beats(0, slen/IN_W - 1, 0);
    tick(4);
    compare_run(slen/IN_W, "R9");
  endtask

  task automatic t_gaps();
    do_reset();
    put_junk(7); put_word(FILL); put_word(FILL); put_word(FILL);
    put_word(K_P); put_word(D2); put_word(D0); put_word(D1); put_word(FILL);
    pad();
    set_off(2, 7);
    drive_beats(0, slen/IN_W - 1, 2);
    tick(4);
    compare_run(slen/IN_W, "R10");
  endtask

  task automatic t_backpressure();
    do_reset();
    put_junk(5); put_word(FILL); put_word(FILL); put_word(FILL);
    put_word(K_N); put_word(D0); put_word(D1); put_word(D2); put_word(D3);
    put_word(FILL); put_word(FILL); put_word(D1); put_word(FILL);
    pad();
    set_off(2, 5);
    bp_on = 1'b1;
    fork
      drive_beats(0, slen/IN_W - 1, 0);
      begin
        for (int i = 0; i < 40; i++) begin
          out_ready = (i % 3 != 0) && (i % 7 != 2);
          tick(1);
        end
        out_ready = 1'b1;
      end
    join
    tick(4);
    bp_on = 1'b0;
    compare_run(slen/IN_W, "R8");
  endtask

  initial begin
    #(CLK_P * 150000);
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    rec_n = 0;
    slen  = 0;
    t_reset();
    t_latency();
    for (int s = 0; s < SW; s++) t_align(s);
    t_hold();
    t_hold_flag();
    t_earliest();
    t_gaps();
    t_backpressure();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule